// File: doc/BRIEF.md
# Interleaved Region Address Swapper

This block sits in a memory controller's address path, ahead of channel selection. It exchanges two equally sized stretches of physical memory: one non-interleaved region below the 16 GiB line and one at the bottom of memory. The point is to let a graphics client work from memory that is interleaved across both channels. The exchange is a bitwise XOR of the 128 MiB block index with a programmed base, so it is its own inverse and needs no lookup.

Software loads one 32-bit configuration word through a single-cycle write port. Each address that arrives with its valid strobe is checked against that word and comes out, possibly remapped, one clock later with its own valid strobe.

Top module: `irs_swap_top`

## Requirements
- R1: After reset, out_valid_o is 0, out_addr_o is 0 and the configuration word is all zeros, so swapping is off.
- R2: When configuration bit 0 (enable) is 0, every address leaves unchanged.
- R3: The configuration fields are decoded at fixed positions: base = bits [9:3], limit = bits [17:11], size = bits [26:20]. Each field counts 128 MiB blocks.
- R4: With enable set, an address below 16 GiB whose block index (address bits [33:27]) lies between base and limit, both ends included, is remapped.
- R5: With enable set, an address below 16 GiB whose block index is strictly less than size is remapped. An index equal to size that lies outside the base-limit window is not remapped.
- R6: An address with any bit at position 34 or above set is never remapped.
- R7: A remapped address equals the input XOR (base << 27). Bits [26:0] and bits [47:34] always pass through unchanged.
- R8: The output appears exactly one cycle after the input and out_valid_o repeats in_valid_i. While in_valid_i is 0, out_addr_o holds its last value.
- R9: A configuration write applies to addresses sampled on the cycle after the write. An address presented in the same cycle as the write uses the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word |
| in_valid_i | input | 1 | Input address valid |
| in_addr_i | input | 48 | System physical address |
| out_valid_o | output | 1 | Output address valid |
| out_addr_o | output | 48 | Remapped address |

## Verification
A wrong configuration register or a mis-decoded field shows on the very next valid output. Either an address that should be remapped moves to the wrong block, or it comes through unchanged. The boundary addresses (index at base, at limit, at limit plus one, at size minus one, at size, and exactly 16 GiB) sit right at the edges of the compare logic, so a wrong comparator shows up as a single mismatched output. A fault in the pipeline register shows at once as a missing or duplicated valid, or as an output that changes while no input is valid.

// File: rtl/irs_pkg.sv
package irs_pkg;
  localparam int unsigned CFG_W     = 32;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned BASE_LSB  = 3;
  localparam int unsigned LIMIT_LSB = 11;
  localparam int unsigned SIZE_LSB  = 20;
  localparam int unsigned FLD_W     = 7;

  typedef struct packed {
    logic             en;
    logic [FLD_W-1:0] base;
    logic [FLD_W-1:0] limit;
    logic [FLD_W-1:0] size;
  } swap_cfg_t;
endpackage

// File: rtl/irs_cfg_reg.sv
module irs_cfg_reg
  import irs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output swap_cfg_t        cfg_o
);
  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (we_i) word_q <= wdata_i;
  end

  always_comb begin
    cfg_o.en    = word_q[EN_BIT];
    cfg_o.base  = word_q[BASE_LSB  +: FLD_W];
    cfg_o.limit = word_q[LIMIT_LSB +: FLD_W];
    cfg_o.size  = word_q[SIZE_LSB  +: FLD_W];
  end
endmodule

// File: rtl/irs_region_match.sv
module irs_region_match
  import irs_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned BLK_LSB = 27,
  parameter int unsigned HI_LSB = 34
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  swap_cfg_t         cfg_i,
  output logic              hit_o
);
  localparam int unsigned IDX_W = HI_LSB - BLK_LSB;

  logic             below_q;
  logic [IDX_W-1:0] idx;
  logic [FLD_W-1:0] idx_ext;
  logic             in_win, under_sz;

  assign below_q  = ~|addr_i[ADDR_W-1:HI_LSB];
  assign idx      = addr_i[HI_LSB-1:BLK_LSB];
  assign idx_ext  = FLD_W'(idx);
  assign in_win   = (idx_ext >= cfg_i.base) && (idx_ext <= cfg_i.limit);
  assign under_sz = idx_ext < cfg_i.size;
  assign hit_o    = cfg_i.en & below_q & (in_win | under_sz);
endmodule

// File: rtl/irs_xor_remap.sv
module irs_xor_remap
  import irs_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned BLK_LSB = 27
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FLD_W-1:0]  base_i,
  input  logic              hit_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] mask;

  always_comb begin
    mask = '0;
    mask[BLK_LSB +: FLD_W] = base_i;
    addr_o = hit_i ? (addr_i ^ mask) : addr_i;
  end
endmodule

// File: rtl/irs_swap_top.sv
module irs_swap_top
  import irs_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned BLK_LSB = 27,
  parameter int unsigned HI_LSB = 34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_addr_o
);
  swap_cfg_t         cfg;
  logic              hit;
  logic              cfg_en;
  logic [ADDR_W-1:0] remap_addr;

  assign cfg_en = cfg.en;

  irs_cfg_reg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  irs_region_match #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .HI_LSB(HI_LSB)) i_match (
    .addr_i (in_addr_i),
    .cfg_i  (cfg),
    .hit_o  (hit)
  );

  irs_xor_remap #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) i_remap (
    .addr_i (in_addr_i),
    .base_i (cfg.base),
    .hit_i  (hit),
    .addr_o (remap_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_addr_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_addr_o <= remap_addr;
    end
  end
endmodule

// File: rtl/irs_swap_chk.sv
module irs_swap_chk #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned BLK_LSB = 27,
  parameter int unsigned HI_LSB = 34
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_en,
  input logic              in_valid_i,
  input logic [ADDR_W-1:0] in_addr_i,
  input logic              out_valid_o,
  input logic [ADDR_W-1:0] out_addr_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> out_valid_o == $past(in_valid_i)); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(in_valid_i)) |-> $stable(out_addr_o)); // R8

  AST_DISABLED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(in_valid_i && !cfg_en)) |-> out_addr_o == $past(in_addr_i)); // R2

  AST_HIGH_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(in_valid_i && (|in_addr_i[ADDR_W-1:HI_LSB]))) |->
      out_addr_o == $past(in_addr_i)); // R6

  AST_OUTER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(in_valid_i)) |->
      (out_addr_o[BLK_LSB-1:0] == $past(in_addr_i[BLK_LSB-1:0]) &&
       out_addr_o[ADDR_W-1:HI_LSB] == $past(in_addr_i[ADDR_W-1:HI_LSB]))); // R7
endmodule

bind irs_swap_top irs_swap_chk #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .HI_LSB(HI_LSB)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_en      (cfg_en),
  .in_valid_i  (in_valid_i),
  .in_addr_i   (in_addr_i),
  .out_valid_o (out_valid_o),
  .out_addr_o  (out_addr_o)
);

// File: tb/test_irs_swap_top.sv
module test_irs_swap_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [47:0] in_addr = '0;
  logic        out_valid;
  logic [47:0] out_addr;

  int total = 0;
  int bad = 0;
  logic [31:0] cur_cfg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irs_swap_top i_irs_swap_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .in_valid_i  (in_valid),
    .in_addr_i   (in_addr),
    .out_valid_o (out_valid),
    .out_addr_o  (out_addr)
  );

  function automatic logic [31:0] mk_cfg(bit en, int base, int limit, int size);
    return 32'(en) | (32'(base) << 3) | (32'(limit) << 11) | (32'(size) << 20);
  endfunction

  function automatic logic [47:0] ref_addr(logic [31:0] c, logic [47:0] a);
    int idx, b, l, s;
    idx = int'(a[33:27]);
    b = int'(c[9:3]); l = int'(c[17:11]); s = int'(c[26:20]);
    if (c[0] && a[47:34] == '0 && ((idx >= b && idx <= l) || idx < s))
      return a ^ (48'(b) << 27);
    return a;
  endfunction

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = w;
  endtask

  task automatic send(string req, logic [47:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 48'(out_valid), 48'd1);
    chk(req, out_addr, ref_addr(cur_cfg, a));
  endtask

  function automatic logic [47:0] blk(int idx, logic [26:0] low);
    return (48'(idx) << 27) | 48'(low);
  endfunction

  task automatic t_reset();
    chk("R1 out_valid", 48'(out_valid), 48'd0);
    chk("R1 out_addr", out_addr, 48'd0);
    send("R1 cleared cfg passes", blk(1, 27'h55));
    chk("R1 explicit", out_addr, blk(1, 27'h55));
  endtask

  task automatic t_disabled();
    write_cfg(mk_cfg(0, 3, 6, 2));
    send("R2 disabled in window", blk(4, 27'h10));
    chk("R2 explicit", out_addr, blk(4, 27'h10));
    send("R2 disabled under size", blk(0, 27'h7));
  endtask

  task automatic t_window();
    write_cfg(mk_cfg(1, 3, 6, 2));
    send("R4 at base", blk(3, 27'h123));
    chk("R4 base explicit", out_addr, blk(0, 27'h123));
    send("R4 at limit", blk(6, 27'h4));
    chk("R4 limit explicit", out_addr, blk(5, 27'h4));
    send("R4 limit plus one", blk(7, 27'h4));
    chk("R4 past limit explicit", out_addr, blk(7, 27'h4));
    send("R3 field decode", blk(5, 27'h1));
  endtask

  task automatic t_size();
    send("R5 size minus one", blk(1, 27'h9));
    chk("R5 explicit", out_addr, blk(2, 27'h9));
    send("R5 at zero", blk(0, 27'h0));
    send("R5 at size", blk(2, 27'h9));
    chk("R5 at size explicit", out_addr, blk(2, 27'h9));
  endtask

  task automatic t_high();
    send("R6 at 16GiB", 48'h4_0000_0000);
    chk("R6 explicit", out_addr, 48'h4_0000_0000);
    send("R6 high with window idx", 48'h8000_0000_0000 | blk(3, 27'h2));
    send("R6 just below 16GiB", 48'h3_FFFF_FFFF);
  endtask

  task automatic t_bits();
    write_cfg(mk_cfg(1, 7'h55, 7'h7F, 0));
    send("R7 xor wide base", blk(7'h60, 27'h7FF_FFFF));
    chk("R7 explicit", out_addr, blk(7'h35, 27'h7FF_FFFF));
  endtask

  task automatic t_hold();
    logic [47:0] last;
    last = out_addr;
    @(negedge clk);
    in_addr = blk(3, 27'h3);
    @(negedge clk);
    chk("R8 no valid", 48'(out_valid), 48'd0);
    chk("R8 addr held", out_addr, last);
  endtask

  task automatic t_cfg_timing();
    logic [31:0] newc;
    write_cfg(mk_cfg(0, 3, 6, 2));
    newc = mk_cfg(1, 3, 6, 2);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = newc;
    in_valid = 1'b1; in_addr = blk(4, 27'h8);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R9 same cycle old cfg", out_addr, blk(4, 27'h8));
    cur_cfg = newc;
    send("R9 next cycle new cfg", blk(4, 27'h8));
    chk("R9 explicit", out_addr, blk(7, 27'h8));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_window();
    t_size();
    t_high();
    t_bits();
    t_hold();
    t_cfg_timing();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule